// File: doc/BRIEF.md
# Four-Channel Serial Audio Frame Master

This block is the master side of a serial audio link that moves four 16-bit channels once per sampling period over a single data wire. It makes the bit clock itself. Each toggle of the bit clock is triggered by one asserted cycle of a system-clock enable, so two enables make one bit-clock period. A 32 kHz sampling period at a 4.608 MHz bit clock holds 144 bit-clock cycles. Only the first 64 of those cycles carry data. The remaining 80 cycles are idle.

During the 64 data cycles the block samples the serial input on each rising bit-clock edge, most significant bit first, with channel 0 arriving first. When the last data bit is in, all four parallel channel outputs update together and a one-cycle valid pulse is raised. A frame identification strobe marks the end of the sample data: it is high for the whole bit-clock cycle that follows the 64th data bit. The same bit clock also times a second serial output, which shifts out a 64-bit test word from a monitoring source. That output is forced to zero in the idle cycles. A synchronous reset restarts the frame at cycle 0.

Top module: `quad_frame_master`

## Requirements
- R1: `bclk` toggles in exactly those system-clock cycles in which `bit_en` was sampled high; it holds its level otherwise. A 0-to-1 change is a rising edge.
- R2: A frame has 144 bit-clock cycles, numbered 0 to 143. The cycle number advances on each falling edge of `bclk` and wraps from 143 to 0, so successive strobe cycles are 144 rising edges apart.
- R3: `frame_id` is 1 for the whole of bit-clock cycle 64 and 0 in every other cycle. It changes only together with a falling edge of `bclk`.
- R4: `sdin` is sampled at the rising edge of cycles 0 to 63, most significant bit first, channels in order 0,1,2,3. Channel n appears on `ch_data[16n+15:16n]`, and its first received bit is bit 15 of that field.
- R5: `ch_valid` is a single system-cycle pulse in the cycle right after the rising edge of cycle 63. `ch_data` takes its new value in that same cycle and keeps it in every cycle where `ch_valid` is low.
- R6: `sdin` is ignored in cycles 64 to 143. Values placed there do not reach `ch_data`.
- R7: `sdout` carries `test_word` most significant bit first in cycles 0 to 63, changing at falling edges of `bclk`. The word is captured as cycle 0 begins, so a change of `test_word` during a frame does not alter that frame's output.
- R8: `sdout` is 0 throughout cycles 64 to 143.
- R9: While `rst` is high, the next state is the restart state: `bclk`=0, cycle 0, `frame_id`=0, `ch_valid`=0, `ch_data`=0, and `sdout` equal to bit 63 of `test_word`. The frame starts again from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | System-clock enable; each high cycle toggles the bit clock |
| sdin | input | 1 | Serial audio data in |
| test_word | input | 64 | Parallel word to be shifted out on `sdout` |
| bclk | output | 1 | Bit clock driven by this master |
| frame_id | output | 1 | End-of-sample-data strobe, high during cycle 64 |
| sdout | output | 1 | Serial test data out |
| ch_data | output | 64 | Four received channels, channel n at bits 16n+15:16n |
| ch_valid | output | 1 | One-cycle pulse when `ch_data` is renewed |

## Verification
The rising edge of `frame_id` and the drop of `sdout` to zero happen at the same falling bit-clock edge, the one that opens cycle 64. The bench checks both at every such edge. A reset is also applied in exactly that cycle while the strobe is high, and the bench then checks that the restart state wins and that the first valid pulse afterwards carries only bits sent after the reset. The rising edge of cycle 63 lands the last data bit and updates the channels in one step. The scoreboard pops the expected words at that point and compares them, while idle-cycle input is kept random to expose any sampling outside the data window.

// File: rtl/qfm_pkg.sv
package qfm_pkg;

    // Level of the generated bit clock; the low phase comes first in each cycle.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } bclk_phase_e;

    // Number of bits needed to count 0 .. n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/qfm_timer.sv
module qfm_timer
    import qfm_pkg::*;
#(
    parameter int FRAME_BITS = 144,
    parameter int DATA_BITS  = 64,
    parameter int CNT_W      = cnt_width(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic             bclk,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next,
    output logic             frame_id
);

    localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] ID_CYC   = CNT_W'(DATA_BITS);

    typedef struct packed {
        bclk_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic             id;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] wrap_cnt;

    always_comb begin
        st_d     = st_q;
        wrap_cnt = (st_q.cnt == LAST_CYC) ? '0 : st_q.cnt + 1'b1;
        rise_stb = tick && (st_q.phase == PH_LOW);
        fall_stb = tick && (st_q.phase == PH_HIGH);
        if (rise_stb) begin
            st_d.phase = PH_HIGH;
        end
        if (fall_stb) begin
            // A new bit-clock cycle opens at each falling edge.
            st_d.phase = PH_LOW;
            st_d.cnt   = wrap_cnt;
            st_d.id    = (wrap_cnt == ID_CYC);
        end
        if (rst) begin
            st_d.phase = PH_LOW;
            st_d.cnt   = '0;
            st_d.id    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bclk     = (st_q.phase == PH_HIGH);
    assign cnt      = st_q.cnt;
    assign cnt_next = wrap_cnt;
    assign frame_id = st_q.id;

endmodule

// File: rtl/qfm_deser.sv
module qfm_deser #(
    parameter int CHANNELS = 4,
    parameter int CH_WIDTH = 16,
    parameter int CNT_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rise_stb,
    input  logic [CNT_W-1:0]             cnt,
    input  logic                         din,
    output logic [CHANNELS*CH_WIDTH-1:0] ch_data,
    output logic                         valid
);

    localparam int               DATA_BITS = CHANNELS * CH_WIDTH;
    localparam logic [CNT_W-1:0] WIN_END   = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_BITS - 1);

    typedef logic [CH_WIDTH-1:0] chan_t;

    typedef struct packed {
        logic [DATA_BITS-1:0]       sr;
        chan_t [CHANNELS-1:0]       ch;
        logic                       valid;
    } des_state_t;

    des_state_t st_d, st_q;
    logic [DATA_BITS-1:0] sr_shift;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        sr_shift   = {st_q.sr[DATA_BITS-2:0], din};
        // Only the data window feeds the shift register.
        if (rise_stb && (cnt < WIN_END)) begin
            st_d.sr = sr_shift;
            if (cnt == LAST_BIT) begin
                for (int n = 0; n < CHANNELS; n++) begin
                    st_d.ch[n] = sr_shift[DATA_BITS-1-n*CH_WIDTH -: CH_WIDTH];
                end
                st_d.valid = 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan_out
        assign ch_data[g*CH_WIDTH +: CH_WIDTH] = st_q.ch[g];
    end

    assign valid = st_q.valid;

endmodule

// File: rtl/qfm_ser.sv
module qfm_ser #(
    parameter int DATA_BITS = 64,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fall_stb,
    input  logic [CNT_W-1:0]     cnt_next,
    input  logic [DATA_BITS-1:0] word,
    output logic                 dout
);

    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(DATA_BITS);

    typedef struct packed {
        logic [DATA_BITS-1:0] sr;
        logic                 dout;
    } ser_state_t;

    ser_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_stb) begin
            if (cnt_next == '0) begin
                // Capture the test word as cycle 0 opens.
                st_d.dout = word[DATA_BITS-1];
                st_d.sr   = {word[DATA_BITS-2:0], 1'b0};
            end else if (cnt_next < WIN_END) begin
                st_d.dout = st_q.sr[DATA_BITS-1];
                st_d.sr   = {st_q.sr[DATA_BITS-2:0], 1'b0};
            end else begin
                st_d.dout = 1'b0;
            end
        end
        if (rst) begin
            st_d.dout = word[DATA_BITS-1];
            st_d.sr   = {word[DATA_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/quad_frame_master.sv
module quad_frame_master
    import qfm_pkg::*;
#(
    parameter int CHANNELS   = 4,
    parameter int CH_WIDTH   = 16,
    parameter int FRAME_BITS = 144
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bit_en,
    input  logic                         sdin,
    input  logic [CHANNELS*CH_WIDTH-1:0] test_word,
    output logic                         bclk,
    output logic                         frame_id,
    output logic                         sdout,
    output logic [CHANNELS*CH_WIDTH-1:0] ch_data,
    output logic                         ch_valid
);

    localparam int DATA_BITS = CHANNELS * CH_WIDTH;
    localparam int CNT_W     = cnt_width(FRAME_BITS);

    logic             rise_stb;
    logic             fall_stb;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] bit_cnt_next;

    qfm_timer #(
        .FRAME_BITS (FRAME_BITS),
        .DATA_BITS  (DATA_BITS),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_en),
        .bclk     (bclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .cnt      (bit_cnt),
        .cnt_next (bit_cnt_next),
        .frame_id (frame_id)
    );

    qfm_deser #(
        .CHANNELS (CHANNELS),
        .CH_WIDTH (CH_WIDTH),
        .CNT_W    (CNT_W)
    ) u_deser (
        .clk      (clk),
        .rst      (rst),
        .rise_stb (rise_stb),
        .cnt      (bit_cnt),
        .din      (sdin),
        .ch_data  (ch_data),
        .valid    (ch_valid)
    );

    qfm_ser #(
        .DATA_BITS (DATA_BITS),
        .CNT_W     (CNT_W)
    ) u_ser (
        .clk      (clk),
        .rst      (rst),
        .fall_stb (fall_stb),
        .cnt_next (bit_cnt_next),
        .word     (test_word),
        .dout     (sdout)
    );

endmodule

// File: rtl/quad_frame_master_chk.sv
module quad_frame_master_chk #(
    parameter int DATA_W    = 64,
    parameter int DATA_BITS = 64,
    parameter int CNT_W     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              bclk,
    input logic              frame_id,
    input logic              sdout,
    input logic [DATA_W-1:0] ch_data,
    input logic              ch_valid,
    input logic [CNT_W-1:0]  bit_cnt
);

    // R1
    bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> (bclk != $past(bclk)));

    // R1
    bclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(bclk));

    // R3
    id_window_chk: assert property (@(posedge clk) disable iff (rst)
        frame_id |-> (bit_cnt == CNT_W'(DATA_BITS)));

    // R3
    id_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(frame_id)) |-> $fell(bclk));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ch_valid |=> !ch_valid);

    // R5
    valid_place_chk: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> (bclk && bit_cnt == CNT_W'(DATA_BITS - 1)));

    // R5
    ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !ch_valid) |-> $stable(ch_data));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt >= CNT_W'(DATA_BITS)) |-> !sdout);

endmodule

bind quad_frame_master quad_frame_master_chk #(
    .DATA_W    (CHANNELS * CH_WIDTH),
    .DATA_BITS (DATA_BITS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bclk     (bclk),
    .frame_id (frame_id),
    .sdout    (sdout),
    .ch_data  (ch_data),
    .ch_valid (ch_valid),
    .bit_cnt  (bit_cnt)
);

// File: tb/quad_frame_master_tb.sv
module quad_frame_master_tb;

    localparam int NCH    = 4;
    localparam int CW     = 16;
    localparam int NBITS  = NCH * CW;
    localparam int FRAME  = 144;
    localparam int FRAMES = 8;
    localparam int WDOG   = 60000;

    logic             clk = 1'b0;
    logic             rst;
    logic             bit_en;
    logic             sdin;
    logic [NBITS-1:0] test_word;
    logic             bclk;
    logic             frame_id;
    logic             sdout;
    logic [NBITS-1:0] ch_data;
    logic             ch_valid;

    always #2.5 clk = ~clk;

    quad_frame_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .sdin      (sdin),
        .test_word (test_word),
        .bclk      (bclk),
        .frame_id  (frame_id),
        .sdout     (sdout),
        .ch_data   (ch_data),
        .ch_valid  (ch_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [NBITS-1:0] exp_q[$];
    logic [NBITS-1:0] fw;
    logic [NBITS-1:0] tw_exp;
    logic [NBITS-1:0] prev_ch;
    int  m_cnt, rise_cnt, frames, fidx;
    logic prev_bclk, prev_en, have_id;

    task automatic check(input string req, input logic [NBITS-1:0] act,
                         input logic [NBITS-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NBITS-1:0] arrange(input logic [NBITS-1:0] w);
        logic [NBITS-1:0] r;
        for (int n = 0; n < NCH; n++) r[n*CW +: CW] = w[NBITS-1-n*CW -: CW];
        return r;
    endfunction

    function automatic logic [NBITS-1:0] pick_frame(input int idx);
        case (idx)
            0:       return '1;
            1:       return '0;
            2:       return {NBITS/8{8'hA5}};
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    // Driver side: choose the next frame's bits and queue the expected channels.
    task automatic push_frame();
        fw = pick_frame(fidx);
        fidx++;
        exp_q.push_back(arrange(fw));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 restart state
        check("R9 bclk", NBITS'(bclk), '0);
        check("R9 frame_id", NBITS'(frame_id), '0);
        check("R9 ch_valid", NBITS'(ch_valid), '0);
        check("R9 ch_data", ch_data, '0);
        check("R9 sdout", NBITS'(sdout), NBITS'(test_word[NBITS-1]));
        exp_q.delete();
        m_cnt = 0; rise_cnt = 0; have_id = 1'b0;
        prev_bclk = 1'b0; prev_en = 1'b0; prev_ch = '0;
        tw_exp = test_word;
        push_frame();
    endtask

    initial begin
        logic did_mid_reset;
        int   cyc;
        logic rose, fell;
        rst = 1'b1; bit_en = 1'b0; sdin = 1'b0;
        test_word = 64'hC3A5_0F1E_9B72_6D48;
        fidx = 0; frames = 0; did_mid_reset = 1'b0; cyc = 0;
        @(negedge clk);
        do_reset();
        while (frames < FRAMES && cyc < WDOG) begin
            cyc++;
            // Monitor
            rose = !prev_bclk && bclk;
            fell = prev_bclk && !bclk;
            // R1 toggle only on an enabled cycle
            check("R1 bclk toggle", NBITS'(bclk != prev_bclk), NBITS'(prev_en));
            if (rose) rise_cnt++;
            if (fell) begin
                m_cnt = (m_cnt + 1) % FRAME;
                if (m_cnt == 0) begin
                    tw_exp = test_word;
                    push_frame();
                end
                // R3 strobe only in cycle 64
                check("R3 frame_id", NBITS'(frame_id), NBITS'(m_cnt == NBITS));
                // R7 / R8 serial test output
                if (m_cnt < NBITS)
                    check("R7 sdout", NBITS'(sdout), NBITS'(tw_exp[NBITS-1-m_cnt]));
                else
                    check("R8 sdout idle", NBITS'(sdout), '0);
                if (m_cnt == NBITS) begin
                    // R2 frame length between strobes
                    if (have_id) check("R2 frame length", NBITS'(rise_cnt), NBITS'(FRAME));
                    have_id = 1'b1;
                    rise_cnt = 0;
                end
                // R7 change of the source word inside a frame
                if (m_cnt == 10) test_word = {$urandom(), $urandom()};
            end
            if (ch_valid) begin
                // R5 pulse placement
                check("R5 valid place", NBITS'(bclk && m_cnt == NBITS - 1), NBITS'(1));
                if (exp_q.size() == 0) begin
                    check("R4 unexpected frame", ch_data, '0);
                    if (ch_data == '0) begin
                        n_bad++;
                        $display("FAIL R4: actual valid without frame expected none");
                    end
                end else begin
                    // R4 / R6 channel order and bit order
                    check("R4 ch_data", ch_data, exp_q.pop_front());
                end
                frames++;
            end else begin
                check("R5 ch_data hold", ch_data, prev_ch);
            end
            prev_ch = ch_data;
            prev_bclk = bclk;
            if (fell && m_cnt == NBITS && frames == 3 && !did_mid_reset) begin
                // R9 reset landing on the strobe cycle
                did_mid_reset = 1'b1;
                do_reset();
                continue;
            end
            // Driver: data in the window, noise elsewhere (R6)
            if (!bclk && m_cnt < NBITS) sdin = fw[NBITS-1-m_cnt];
            else                        sdin = 1'($urandom());
            bit_en = (frames < 2) ? 1'b1 : 1'($urandom() % 4 != 0);
            prev_en = bit_en;
            @(negedge clk);
        end
        if (frames < FRAMES) begin
            n_bad++;
            $display("FAIL R5 watchdog: actual %0d frames expected %0d", frames, FRAMES);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule